// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM with Single-Cycle Deselect

This block is a behavioural synchronous static memory with four byte lanes. Every command input is sampled on the rising clock edge into an input register. A read then passes through one more register stage before it reaches the output bus. Writes are decided by two controls. An active-low write-all control commits every lane. Otherwise an active-low lane-write gate, together with active-low per-lane selects, commits only the chosen lanes. The address is applied by the caller every cycle, so any burst sequencing is done by an external address generator, and a new address may be presented on every cycle.

Three chip selects gate the device: two active low and one active high. When the device is not selected, the output drive is released on the very edge at which read data would otherwise have been presented, so no extra cycle of drive follows the last read. An active-low output enable and an active-high sleep input act on the output drive at once, without waiting for a clock. While sleep is high, commands are ignored and stored contents are kept. The output side has a valid flag and no ready signal. A memory cannot stall, so the consumer must take each beat in the cycle its valid flag is high. Whenever valid is low the data bus reads zero.

Top module: `sram_pipe_core`

## Requirements
- R1: The block accepts a command only when, at the rising edge, `sel0_n`=0, `sel1`=1, `sel2_n`=0 and `sleep`=0. Under any other combination it performs neither a read nor a write.
- R2: When `all_wr_n`=0 on a selected edge, all four lanes of the addressed word are written, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R3: When `all_wr_n`=1, `lane_wr_en_n`=0 and `lane_sel_n[i]`=0, lane i (bits 8i+7 down to 8i) is written. Lanes whose select is high keep their old contents.
- R4: A selected edge that is not a write is a read. A read sampled at edge k puts the addressed word on `rdata` with `rvalid`=1 after edge k+1. This is one register stage beyond the input register.
- R5: Reads issued on consecutive cycles produce data on consecutive cycles, one word per cycle, in issue order.
- R6: A write sampled at edge k is committed at edge k+1. A read of the same address sampled at edge k+1 returns the new data.
- R7: A deselect or a write sampled at edge k leaves `rvalid`=0 after edge k+1. The drive ends at the same edge a read's data would have appeared, not one cycle later.
- R8: `out_en_n`=1 forces `rvalid`=0 and `rdata`=0 at once, without a clock edge, and it does not disturb the read pipeline.
- R9: `sleep`=1 forces `rvalid`=0 at once. Commands sampled while it is high, including a write already captured in the input register, change no stored word. Contents are readable unchanged after sleep ends.
- R10: `rdata` is zero in every cycle in which `rvalid` is 0.
- R11: After reset, `rvalid` is 0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of pipeline control |
| addr | input | AW | Word address, sampled each edge |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Gate for per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| wdata | input | DW | Write data, sampled with the command |
| rdata | output | DW | Read data, zero when not valid |
| rvalid | output | 1 | Output drive / data valid flag |

## Verification
A full sweep first writes every address with the write-all control and reads it all back in one unbroken run of reads. This separates correct latency and ordering from off-by-one-cycle errors. A second sweep writes all sixteen lane-select patterns, each to its own address. Reading these back shows whether the masking is correct or lanes are swapped, and a write-all issued over conflicting lane selects checks the override. All eight chip-select combinations are tried against one address, and only the enabling combination may change it. Mixed sequences of reads, deselects and writes, a same-address write followed by a read, and mid-cycle changes of the output enable and sleep inputs check how the drive is released and that writes are ignored during sleep.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } cmd_e;
endpackage

// File: rtl/sram_cmd_decode.sv
`timescale 1ns/1ps
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             sleep,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output cmd_e             cmd,
  output logic [LANES-1:0] lane_mask
);
  logic chosen;
  logic any_lane;
  logic is_write;

  always_comb begin
    chosen   = !sel0_n && sel1 && !sel2_n && !sleep;
    any_lane = |(~lane_sel_n);
    is_write = !all_wr_n || (!lane_wr_en_n && any_lane);
    if (!all_wr_n)          lane_mask = '1;
    else if (!lane_wr_en_n) lane_mask = ~lane_sel_n;
    else                    lane_mask = '0;
    if (!chosen)            cmd = CMD_NOP;
    else if (is_write)      cmd = CMD_WR;
    else                    cmd = CMD_RD;
  end
endmodule

// File: rtl/sram_in_stage.sv
`timescale 1ns/1ps
module sram_in_stage
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int AW     = 4,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd_d,
  input  logic [AW-1:0]    addr_d,
  input  logic [DW-1:0]    data_d,
  input  logic [LANES-1:0] mask_d,
  output cmd_e             cmd_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    data_q,
  output logic [LANES-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      mask_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      mask_q <= mask_d;
    end
    addr_q <= addr_d;
    data_q <= data_d;
  end

  // R3: a captured write always carries at least one lane
  a_r3_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WR) |-> (mask_q != '0));
endmodule

// File: rtl/sram_lane_bank.sv
`timescale 1ns/1ps
module sram_lane_bank #(
  parameter int LANE_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  logic [LANE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
    if (rd_en) rdata <= store[addr];
  end
endmodule

// File: rtl/sram_out_stage.sv
`timescale 1ns/1ps
module sram_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_pending,
  input  logic [DW-1:0] bank_q,
  input  logic          out_en_n,
  input  logic          sleep,
  output logic          drive_q,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= rd_pending;
  end

  always_comb begin
    rvalid = drive_q && !out_en_n && !sleep;
    rdata  = rvalid ? bank_q : '0;
  end
endmodule

// File: rtl/sram_pipe_core.sv
`timescale 1ns/1ps
module sram_pipe_core
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 16,
  localparam int DW    = LANES * LANE_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             out_en_n,
  input  logic             sleep,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  cmd_e             cmd_d;
  cmd_e             cmd_q;
  logic [LANES-1:0] mask_d;
  logic [LANES-1:0] mask_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [DW-1:0]    bank_q;
  logic             drive_q;
  logic             rd_go;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .sleep(sleep),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .cmd(cmd_d), .lane_mask(mask_d)
  );

  sram_in_stage #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_in (
    .clk(clk), .rst_n(rst_n), .cmd_d(cmd_d), .addr_d(addr), .data_d(wdata),
    .mask_d(mask_d), .cmd_q(cmd_q), .addr_q(addr_q), .data_q(data_q), .mask_q(mask_q)
  );

  assign rd_go = (cmd_q == CMD_RD);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = (cmd_q == CMD_WR) && mask_q[g] && !sleep;
    sram_lane_bank #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .wr_en(lane_we), .rd_en(rd_go), .addr(addr_q),
      .wdata(data_q[g*LANE_W +: LANE_W]), .rdata(bank_q[g*LANE_W +: LANE_W])
    );
  end

  sram_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_pending(rd_go), .bank_q(bank_q),
    .out_en_n(out_en_n), .sleep(sleep), .drive_q(drive_q),
    .rdata(rdata), .rvalid(rvalid)
  );

  logic pins_chosen;
  logic pins_write;
  assign pins_chosen = !sel0_n && sel1 && !sel2_n && !sleep;
  assign pins_write  = !all_wr_n || (!lane_wr_en_n && (lane_sel_n != '1));

  // R1: anything but the enabling select pattern captures no command
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_chosen |=> (cmd_q == CMD_NOP));
  // R2: write-all captures a full lane mask
  a_r2_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_chosen && !all_wr_n) |=> (cmd_q == CMD_WR && mask_q == '1));
  // R4: a read drives the output after the second edge
  a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_chosen && !pins_write) |=> ##1 drive_q);
  // R7: deselect or write releases drive with no extra cycle
  a_r7_single_cycle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_chosen || pins_write) |=> ##1 !drive_q);
  // R9: sleep holds the output off
  a_r9_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rvalid);
  // R10: bus is zero whenever not valid
  a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));
endmodule

// File: tb/sram_pipe_core_bench.sv
`timescale 1ns/1ps
module sram_pipe_core_bench;
  localparam int LANES = 4, LANE_W = 8, DEPTH = 16;
  localparam int DW = LANES * LANE_W, AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sel0_n, sel1, sel2_n, all_wr_n, lane_wr_en_n, out_en_n, sleep;
  logic [AW-1:0] addr;
  logic [LANES-1:0] lane_sel_n;
  logic [DW-1:0] wdata, rdata;
  logic rvalid;

  sram_pipe_core #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_sram_pipe_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int vectors = 0, errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  int m_cmd = 0;               // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [LANES-1:0] m_mask;
  logic o_v = 1'b0;
  logic [DW-1:0] o_d = '0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    logic ev;
    ev = o_v && !out_en_n && !sleep;
    check({req, " valid"}, {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, ev});
    check({req, " data"}, rdata, ev ? o_d : '0);   // R10 zero when invalid
  endtask

  // one clock cycle: apply pins, advance model at the edge, compare after it
  task automatic cyc(input logic s0n, input logic s1, input logic s2n,
                     input logic gwn, input logic bwn, input logic [LANES-1:0] ln,
                     input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic oen, input logic slp, input string req);
    logic chosen, wr;
    sel0_n = s0n; sel1 = s1; sel2_n = s2n; all_wr_n = gwn; lane_wr_en_n = bwn;
    lane_sel_n = ln; addr = a; wdata = d; out_en_n = oen; sleep = slp;
    @(posedge clk);
    if (m_cmd == 1) begin o_v = 1'b1; o_d = ref_mem[m_addr]; end
    else o_v = 1'b0;
    if (m_cmd == 2 && !slp)
      for (int i = 0; i < LANES; i++)
        if (m_mask[i]) ref_mem[m_addr][i*LANE_W +: LANE_W] = m_data[i*LANE_W +: LANE_W];
    chosen = !s0n && s1 && !s2n && !slp;
    wr = !gwn || (!bwn && (ln != '1));
    m_cmd = !chosen ? 0 : (wr ? 2 : 1);
    m_addr = a; m_data = d;
    m_mask = !gwn ? '1 : (!bwn ? ~ln : '0);
    @(negedge clk);
    compare(req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    cyc(0, 1, 0, 1, 1, '1, a, '0, 0, 0, req);
  endtask
  task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LANES-1:0] ln, input string req);
    cyc(0, 1, 0, 0, 0, ln, a, d, 0, 0, req);
  endtask
  task automatic wr_lanes(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LANES-1:0] ln, input string req);
    cyc(0, 1, 0, 1, 0, ln, a, d, 0, 0, req);
  endtask
  task automatic idle(input string req);
    cyc(1, 1, 0, 1, 1, '1, '0, '0, 0, 0, req);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; sel0_n = 1; sel1 = 0; sel2_n = 1; all_wr_n = 1; lane_wr_en_n = 1;
    lane_sel_n = '1; addr = '0; wdata = '0; out_en_n = 0; sleep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare("R11 reset");

    // R2 fill every word through write-all with conflicting lane selects
    for (int a = 0; a < DEPTH; a++)
      wr_all(AW'(a), (32'h0101_0101 * (a + 1)) ^ 32'hF0F0_0000, 4'(a), "R2 fill");
    // R4/R5 back-to-back reads of all words
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R5 burst");
    idle("R4 tail"); idle("R7 after burst");

    // R3 every lane pattern, pattern m stored at address m
    for (int m = 0; m < 16; m++)
      wr_lanes(AW'(m), ~(32'h1111_1111 * m), ~4'(m), "R3 lane write");
    for (int m = 0; m < 16; m++) rd(AW'(m), "R3 lane readback");
    idle("R3 tail");

    // R6 write then same-address read next cycle
    for (int a = 0; a < DEPTH; a += 3) begin
      wr_all(AW'(a), 32'hC0DE_0000 + a, '0, "R6 write");
      rd(AW'(a), "R6 read-after-write");
    end
    idle("R6 tail"); idle("R6 tail");

    // R1 all select combinations against address 5
    for (int e = 0; e < 8; e++) begin
      cyc(e[0], e[1], e[2], 0, 1, '1, 4'd5, 32'hE000_0000 + e, 0, 0, "R1 select write");
      idle("R1 gap");
      rd(4'd5, "R1 select readback");
      idle("R1 gap");
      idle("R1 gap");
    end

    // R7 drive release patterns
    rd(4'd1, "R7 seq"); rd(4'd2, "R7 seq"); idle("R7 deselect");
    rd(4'd3, "R7 seq"); wr_all(4'd9, 32'h5A5A_5A5A, '1, "R7 write");
    rd(4'd9, "R7 seq"); idle("R7 deselect"); idle("R7 deselect");
    rd(4'd4, "R7 seq"); cyc(0, 0, 0, 1, 1, '1, 4'd4, '0, 0, 0, "R7 high select off");
    idle("R7 deselect");

    // R8 asynchronous output enable
    rd(4'd7, "R8 read"); idle("R8 data cycle");
    #0.5 out_en_n = 1; #0.5;
    check("R8 oe off valid", {31'd0, rvalid}, 32'd0);
    check("R8 oe off data", rdata, 32'd0);
    out_en_n = 0; #0.5;
    check("R8 oe back valid", {31'd0, rvalid}, 32'd1);
    check("R8 oe back data", rdata, ref_mem[7]);
    cyc(0, 1, 0, 1, 1, '1, 4'd8, '0, 1, 0, "R8 read oe high");
    idle("R8 pipeline intact");

    // R9 asynchronous sleep, writes ignored, contents retained
    rd(4'd6, "R9 read"); idle("R9 data cycle");
    #0.5 sleep = 1; #0.5;
    check("R9 sleep off valid", {31'd0, rvalid}, 32'd0);
    check("R9 sleep off data", rdata, 32'd0);
    sleep = 0; #0.5;
    check("R9 wake valid", {31'd0, rvalid}, 32'd1);
    cyc(0, 1, 0, 0, 0, '0, 4'd3, 32'hDEAD_BEEF, 0, 1, "R9 write in sleep");
    cyc(0, 1, 0, 0, 0, '0, 4'd3, 32'hBAD0_BAD0, 0, 0, "R9 write before sleep");
    cyc(1, 1, 0, 1, 1, '1, 4'd3, '0, 0, 1, "R9 captured write blocked");
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R9 retained");
    idle("R9 tail"); idle("R9 tail");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule